// File: doc/BRIEF.md
# Cache Enable Sequencer

This block brings an outer (second level) cache online at start-up without corrupting memory. On a start pulse it reads a processor features register once. If the prefetch-disable flag in that register is clear, it writes the register back with the flag set. If the outer cache is already enabled, it stops there. Otherwise it runs a fixed bring-up sequence. Each step is a request/acknowledge handshake on a one-hot step bus or on the register port.

The outer cache may only change state while both first level caches are off. The block therefore samples whether the data cache and the instruction cache are on before it touches them, and it keeps those flags. It then turns the caches off in the safe order: it flushes a dirty data cache before disabling it, and it disables the instruction cache before invalidating it. It invalidates the whole outer cache and writes the enable flag. Finally it turns back on only the first level caches that had been on. Interrupts are masked while the data cache is flushed and switched off. A one-cycle done pulse marks the return to idle.

Top module: `cache_enable_seq`

## Requirements
- R1: After reset the block is idle: no step request, no register read or write request, `done_o` and `irq_mask_o` low. It stays that way until `start_i` is seen.
- R2: Each run begins with one register read. If bit 24 (prefetch disable) of the read value is 0, the next action is a register write of the read value with bit 24 set. If bit 24 is 1, no such write is issued.
- R3: If bit 22 (outer cache enable) of the read value is 1, the run ends after the optional prefetch write, with no step request at all.
- R4: When the data cache was on at the decision point, step bit 0 (flush data cache) is requested, then step bit 1 (disable data cache). When the data cache was off, neither is requested.
- R5: When the instruction cache was on at the decision point, step bit 2 (disable instruction cache) is requested, then step bit 3 (invalidate instruction cache). When the instruction cache was off, neither is requested.
- R6: Step bit 4 (invalidate whole outer cache) always comes after the first level caches are off. It is followed by a register write whose data is the features value with bits 22 and 24 set and every other bit kept.
- R7: After the enable write, step bit 5 (enable instruction cache) is requested and then step bit 6 (enable data cache). Each is requested only if that cache was on at the decision point, even if its live status input has since dropped.
- R8: At most one request is active at a time. A request and its write data stay unchanged until the matching acknowledge is sampled, and it drops the cycle after.
- R9: `irq_mask_o` is high exactly while step bit 0 or step bit 1 is requested, and low otherwise.
- R10: `done_o` is a single-cycle pulse, one per run, with no request active. A `start_i` pulse that arrives during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a bring-up run (accepted only when idle) |
| done_o | output | 1 | One-cycle pulse when the run has finished |
| irq_mask_o | output | 1 | Interrupt mask during data cache flush and disable |
| reg_rd_req_o | output | 1 | Features register read request |
| reg_rd_ack_i | input | 1 | Read acknowledge, data valid with it |
| reg_rd_data_i | input | DATA_W | Features register read value |
| reg_wr_req_o | output | 1 | Features register write request |
| reg_wr_ack_i | input | 1 | Write acknowledge |
| reg_wr_data_o | output | DATA_W | Features register write value |
| dc_on_i | input | 1 | Live status: data cache enabled |
| ic_on_i | input | 1 | Live status: instruction cache enabled |
| step_req_o | output | 7 | One-hot cache step request (bit meanings in R4 to R7) |
| step_ack_i | input | 1 | Acknowledge for the active step request |

## Verification
The hardest case to reach is a restore decision that must rest on remembered state rather than on the live status pins. In a real system those pins fall as soon as the caches are disabled. The bench's cache responder therefore behaves like real caches: it clears the data or instruction cache status when it acknowledges a disable step and sets it again when it acknowledges an enable step. A design that looked at the live pins would skip the restore. The stimulus table covers every on/off mix of the two caches and both states of each features flag, with acknowledge delays from zero to three cycles so that request holding is exercised.

// File: rtl/cesq_pkg.sv
package cesq_pkg;

   localparam int unsigned N_STEP = 7;

   // one-hot step bus positions
   localparam int unsigned STP_DC_FLUSH = 0;
   localparam int unsigned STP_DC_OFF   = 1;
   localparam int unsigned STP_IC_OFF   = 2;
   localparam int unsigned STP_IC_INV   = 3;
   localparam int unsigned STP_L2_INV   = 4;
   localparam int unsigned STP_IC_ON    = 5;
   localparam int unsigned STP_DC_ON    = 6;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_READ,
      ST_WR_PF,
      ST_DECIDE,
      ST_DC_FLUSH,
      ST_DC_OFF,
      ST_IC_OFF,
      ST_IC_INV,
      ST_L2_INV,
      ST_WR_EN,
      ST_IC_ON,
      ST_DC_ON,
      ST_FINISH
   } seq_state_t;

endpackage

// File: rtl/cesq_feat_shadow.sv
module cesq_feat_shadow #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PF_BIT = 24,
   parameter int unsigned EN_BIT = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req_i,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              wr_req_i,
   input  logic              wr_ack_i,
   input  logic              sel_en_i,
   output logic              en_set_o,
   output logic [DATA_W-1:0] wr_data_o
);

   localparam logic [DATA_W-1:0] PF_MASK = DATA_W'(1) << PF_BIT;
   localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

   logic [DATA_W-1:0] shadow_q;

   always_comb begin
      wr_data_o = shadow_q | (sel_en_i ? EN_MASK : PF_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (rd_req_i && rd_ack_i) begin
         shadow_q <= rd_data_i;
      end else if (wr_req_i && wr_ack_i) begin
         shadow_q <= wr_data_o;
      end
   end

   assign en_set_o = shadow_q[EN_BIT];

endmodule

// File: rtl/cesq_l1_memory.sv
module cesq_l1_memory #(
   parameter int unsigned N_L1 = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture_i,
   input  logic [N_L1-1:0] on_i,
   output logic [N_L1-1:0] was_on_o
);

   for (genvar g = 0; g < N_L1; g++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (capture_i) begin
            flag_q <= on_i[g];
         end
      end
      assign was_on_o[g] = flag_q;
   end

endmodule

// File: rtl/cesq_fsm.sv
module cesq_fsm
   import cesq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_ack_i,
   input  logic              rd_pf_set_i,
   input  logic              wr_ack_i,
   input  logic              en_set_i,
   input  logic              dc_now_i,
   input  logic              ic_now_i,
   input  logic              dc_was_i,
   input  logic              ic_was_i,
   input  logic              step_ack_i,
   output logic              capture_o,
   output logic              rd_req_o,
   output logic              wr_req_o,
   output logic              wr_sel_en_o,
   output logic [N_STEP-1:0] step_req_o,
   output logic              irq_mask_o,
   output logic              done_o
);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (start_i) state_d = ST_READ;
         ST_READ:     if (rd_ack_i) state_d = rd_pf_set_i ? ST_DECIDE : ST_WR_PF;
         ST_WR_PF:    if (wr_ack_i) state_d = ST_DECIDE;
         ST_DECIDE: begin
            if (en_set_i)      state_d = ST_FINISH;
            else if (dc_now_i) state_d = ST_DC_FLUSH;
            else if (ic_now_i) state_d = ST_IC_OFF;
            else               state_d = ST_L2_INV;
         end
         ST_DC_FLUSH: if (step_ack_i) state_d = ST_DC_OFF;
         ST_DC_OFF:   if (step_ack_i) state_d = ic_was_i ? ST_IC_OFF : ST_L2_INV;
         ST_IC_OFF:   if (step_ack_i) state_d = ST_IC_INV;
         ST_IC_INV:   if (step_ack_i) state_d = ST_L2_INV;
         ST_L2_INV:   if (step_ack_i) state_d = ST_WR_EN;
         ST_WR_EN: begin
            if (wr_ack_i) begin
               if (ic_was_i)      state_d = ST_IC_ON;
               else if (dc_was_i) state_d = ST_DC_ON;
               else               state_d = ST_FINISH;
            end
         end
         ST_IC_ON:    if (step_ack_i) state_d = dc_was_i ? ST_DC_ON : ST_FINISH;
         ST_DC_ON:    if (step_ack_i) state_d = ST_FINISH;
         ST_FINISH:   state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      step_req_o = '0;
      unique case (state_q)
         ST_DC_FLUSH: step_req_o[STP_DC_FLUSH] = 1'b1;
         ST_DC_OFF:   step_req_o[STP_DC_OFF]   = 1'b1;
         ST_IC_OFF:   step_req_o[STP_IC_OFF]   = 1'b1;
         ST_IC_INV:   step_req_o[STP_IC_INV]   = 1'b1;
         ST_L2_INV:   step_req_o[STP_L2_INV]   = 1'b1;
         ST_IC_ON:    step_req_o[STP_IC_ON]    = 1'b1;
         ST_DC_ON:    step_req_o[STP_DC_ON]    = 1'b1;
         default:     step_req_o = '0;
      endcase
   end

   assign capture_o   = (state_q == ST_DECIDE);
   assign rd_req_o    = (state_q == ST_READ);
   assign wr_req_o    = (state_q == ST_WR_PF) || (state_q == ST_WR_EN);
   assign wr_sel_en_o = (state_q == ST_WR_EN);
   assign irq_mask_o  = (state_q == ST_DC_FLUSH) || (state_q == ST_DC_OFF);
   assign done_o      = (state_q == ST_FINISH);

endmodule

// File: rtl/cache_enable_seq.sv
module cache_enable_seq #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PF_BIT = 24,
   parameter int unsigned EN_BIT = 22
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   output logic                          done_o,
   output logic                          irq_mask_o,
   output logic                          reg_rd_req_o,
   input  logic                          reg_rd_ack_i,
   input  logic [DATA_W-1:0]             reg_rd_data_i,
   output logic                          reg_wr_req_o,
   input  logic                          reg_wr_ack_i,
   output logic [DATA_W-1:0]             reg_wr_data_o,
   input  logic                          dc_on_i,
   input  logic                          ic_on_i,
   output logic [cesq_pkg::N_STEP-1:0]   step_req_o,
   input  logic                          step_ack_i
);

   localparam int unsigned N_L1  = 2;
   localparam int unsigned IDX_D = 0;
   localparam int unsigned IDX_I = 1;

   if (PF_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_bad_bit
      $error("flag bit position outside the register width");
   end
   if (PF_BIT == EN_BIT) begin : g_same_bit
      $error("prefetch and enable flags must differ");
   end

   logic            capture;
   logic            wr_sel_en;
   logic            en_set;
   logic [N_L1-1:0] l1_now;
   logic [N_L1-1:0] l1_was;

   assign l1_now[IDX_D] = dc_on_i;
   assign l1_now[IDX_I] = ic_on_i;

   cesq_feat_shadow #(
      .DATA_W (DATA_W),
      .PF_BIT (PF_BIT),
      .EN_BIT (EN_BIT)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req_i  (reg_rd_req_o),
      .rd_ack_i  (reg_rd_ack_i),
      .rd_data_i (reg_rd_data_i),
      .wr_req_i  (reg_wr_req_o),
      .wr_ack_i  (reg_wr_ack_i),
      .sel_en_i  (wr_sel_en),
      .en_set_o  (en_set),
      .wr_data_o (reg_wr_data_o)
   );

   cesq_l1_memory #(
      .N_L1 (N_L1)
   ) u_l1mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .on_i      (l1_now),
      .was_on_o  (l1_was)
   );

   cesq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rd_ack_i    (reg_rd_ack_i),
      .rd_pf_set_i (reg_rd_data_i[PF_BIT]),
      .wr_ack_i    (reg_wr_ack_i),
      .en_set_i    (en_set),
      .dc_now_i    (l1_now[IDX_D]),
      .ic_now_i    (l1_now[IDX_I]),
      .dc_was_i    (l1_was[IDX_D]),
      .ic_was_i    (l1_was[IDX_I]),
      .step_ack_i  (step_ack_i),
      .capture_o   (capture),
      .rd_req_o    (reg_rd_req_o),
      .wr_req_o    (reg_wr_req_o),
      .wr_sel_en_o (wr_sel_en),
      .step_req_o  (step_req_o),
      .irq_mask_o  (irq_mask_o),
      .done_o      (done_o)
   );

endmodule

// File: rtl/cesq_checker.sv
module cesq_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PF_BIT = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic              irq_mask_o,
   input logic              reg_rd_req_o,
   input logic              reg_wr_req_o,
   input logic              reg_wr_ack_i,
   input logic [DATA_W-1:0] reg_wr_data_o,
   input logic [6:0]        step_req_o,
   input logic              step_ack_i
);

   a_r8_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step_req_o, reg_rd_req_o, reg_wr_req_o}));

   a_r8_step_held: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req_o != '0 && !step_ack_i) |=> $stable(step_req_o));

   a_r8_step_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req_o != '0 && step_ack_i) |=> ((step_req_o & $past(step_req_o)) == '0));

   a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_req_o && !reg_wr_ack_i) |=> (reg_wr_req_o && $stable(reg_wr_data_o)));

   a_r2_pf_in_every_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_req_o |-> reg_wr_data_o[PF_BIT]);

   a_r9_mask_on: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req_o[0] || step_req_o[1]) |-> irq_mask_o);

   a_r9_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_req_o || reg_wr_req_o || step_req_o[6:2] != '0) |-> !irq_mask_o);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!reg_rd_req_o && !reg_wr_req_o && step_req_o == '0 && !irq_mask_o));

endmodule

bind cache_enable_seq cesq_checker #(
   .DATA_W (DATA_W),
   .PF_BIT (PF_BIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .done_o        (done_o),
   .irq_mask_o    (irq_mask_o),
   .reg_rd_req_o  (reg_rd_req_o),
   .reg_wr_req_o  (reg_wr_req_o),
   .reg_wr_ack_i  (reg_wr_ack_i),
   .reg_wr_data_o (reg_wr_data_o),
   .step_req_o    (step_req_o),
   .step_ack_i    (step_ack_i)
);

// File: tb/cache_enable_seq_test.sv
module cache_enable_seq_test;

   localparam int unsigned DW = 32;
   localparam logic [31:0] PF = 32'h0100_0000;
   localparam logic [31:0] EN = 32'h0040_0000;
   localparam logic [31:0] BASE = 32'h0A1A_0F0F;

   // {pf, en, dc, ic, delay[2:0]}
   localparam logic [6:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 1'b1, 3'd0},
      {1'b1, 1'b0, 1'b1, 1'b1, 3'd2},
      {1'b0, 1'b0, 1'b0, 1'b0, 3'd1},
      {1'b0, 1'b0, 1'b1, 1'b0, 3'd3},
      {1'b1, 1'b0, 1'b0, 1'b1, 3'd0},
      {1'b0, 1'b1, 1'b1, 1'b1, 3'd1},
      {1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
      {1'b1, 1'b0, 1'b0, 1'b0, 3'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          done;
   logic          irq_mask;
   logic          rd_req;
   logic          rd_ack;
   logic [DW-1:0] rd_data;
   logic          wr_req;
   logic          wr_ack;
   logic [DW-1:0] wr_data;
   logic          dc_on;
   logic          ic_on;
   logic [6:0]    step_req;
   logic          step_ack;

   always #5 clk = ~clk;

   cache_enable_seq uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start),
      .done_o        (done),
      .irq_mask_o    (irq_mask),
      .reg_rd_req_o  (rd_req),
      .reg_rd_ack_i  (rd_ack),
      .reg_rd_data_i (rd_data),
      .reg_wr_req_o  (wr_req),
      .reg_wr_ack_i  (wr_ack),
      .reg_wr_data_o (wr_data),
      .dc_on_i       (dc_on),
      .ic_on_i       (ic_on),
      .step_req_o    (step_req),
      .step_ack_i    (step_ack)
   );

   // stimulus-side settings, written only by the main process
   logic [31:0] feat_init = '0;
   logic        dc_init = 1'b0;
   logic        ic_init = 1'b0;
   int          dly = 0;
   logic        load_req = 1'b0;

   // responder-side records
   int          got [16];
   int          n_got = 0;
   logic [31:0] wgot [4];
   int          n_wr = 0;
   int          done_cnt = 0;
   int          r_checks = 0;
   int          r_errors = 0;

   int          checks = 0;
   int          errors = 0;

   // cache and register responder: behaves like real caches
   int          cnt = 0;
   bit          pending = 0;
   bit          acking = 0;
   int          cur_code = 0;
   logic [6:0]  cur_step = '0;

   assign rd_data = feat_init;

   initial begin
      rd_ack = 1'b0; wr_ack = 1'b0; step_ack = 1'b0;
      dc_on = 1'b0; ic_on = 1'b0;
   end

   always @(negedge clk) begin
      if (load_req) begin
         dc_on = dc_init; ic_on = ic_init;
         n_got = 0; n_wr = 0; done_cnt = 0;
         pending = 0; acking = 0;
         rd_ack = 1'b0; wr_ack = 1'b0; step_ack = 1'b0;
      end else begin
         if (done) done_cnt++;
         if (acking) begin
            rd_ack = 1'b0; wr_ack = 1'b0; step_ack = 1'b0;
            acking = 0; pending = 0;
         end else if (pending) begin
            // R8: request must stay unchanged while unacknowledged
            r_checks++;
            if (step_req !== cur_step || (cur_code == 1 && !rd_req) || (cur_code == 2 && !wr_req)) begin
               r_errors++;
               $display("FAIL R8 request changed before ack: step=%b expected %b", step_req, cur_step);
            end
         end else if (rd_req || wr_req || step_req != '0) begin
            cur_step = step_req;
            if (rd_req) cur_code = 1;
            else if (wr_req) cur_code = 2;
            else begin
               for (int i = 0; i < 7; i++) if (step_req[i]) cur_code = 3 + i;
            end
            if (n_got < 16) got[n_got] = cur_code;
            n_got++;
            if (cur_code == 2) begin
               if (n_wr < 4) wgot[n_wr] = wr_data;
               n_wr++;
            end
            // R9: mask only during data cache flush / disable
            r_checks++;
            if (irq_mask !== ((cur_code == 3) || (cur_code == 4))) begin
               r_errors++;
               $display("FAIL R9 irq_mask=%b during step code %0d, expected %b",
                        irq_mask, cur_code, (cur_code == 3) || (cur_code == 4));
            end
            pending = 1; cnt = dly;
         end
         if (pending && !acking) begin
            if (cnt == 0) begin
               acking = 1;
               if (cur_code == 1) rd_ack = 1'b1;
               else if (cur_code == 2) wr_ack = 1'b1;
               else begin
                  step_ack = 1'b1;
                  if (cur_code == 4) dc_on = 1'b0;
                  if (cur_code == 5) ic_on = 1'b0;
                  if (cur_code == 8) ic_on = 1'b1;
                  if (cur_code == 9) dc_on = 1'b1;
               end
            end else begin
               cnt--;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int code);
      case (code)
         1, 2:    return "R2";
         3, 4:    return "R4";
         5, 6:    return "R5";
         7:       return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic run_vector(input int v, input bit extra_start);
      logic [6:0]  e;
      int          exp_seq [16];
      int          n_exp;
      logic [31:0] exp_w [4];
      int          n_ew;
      logic [31:0] f;
      int          waited;
      e = VEC[v];
      f = (BASE & ~(PF | EN)) | (e[6] ? PF : 32'h0) | (e[5] ? EN : 32'h0);
      // expected order from the requirements
      n_exp = 0; n_ew = 0;
      exp_seq[n_exp++] = 1;
      if (!e[6]) begin exp_seq[n_exp++] = 2; exp_w[n_ew++] = f | PF; end
      if (!e[5]) begin
         if (e[4]) begin exp_seq[n_exp++] = 3; exp_seq[n_exp++] = 4; end
         if (e[3]) begin exp_seq[n_exp++] = 5; exp_seq[n_exp++] = 6; end
         exp_seq[n_exp++] = 7;
         exp_seq[n_exp++] = 2; exp_w[n_ew++] = f | PF | EN;
         if (e[3]) exp_seq[n_exp++] = 8;
         if (e[4]) exp_seq[n_exp++] = 9;
      end

      @(negedge clk);
      feat_init = f; dc_init = e[4]; ic_init = e[3]; dly = int'(e[2:0]);
      load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited = 0;
      while (done_cnt == 0 && waited < 300) begin
         if (extra_start && waited == 4) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         waited++;
      end
      start = 1'b0;
      repeat (4) @(negedge clk);

      if (e[5]) check(n_got == n_exp, "R3", $sformatf("vec %0d action count", v), n_got, n_exp);
      else      check(n_got == n_exp, "R6", $sformatf("vec %0d action count", v), n_got, n_exp);
      for (int i = 0; i < n_exp && i < n_got && i < 16; i++)
         check(got[i] == exp_seq[i], tag_of(exp_seq[i]),
               $sformatf("vec %0d action %0d code", v, i), got[i], exp_seq[i]);
      check(n_wr == n_ew, "R2", $sformatf("vec %0d write count", v), n_wr, n_ew);
      for (int i = 0; i < n_ew && i < n_wr && i < 4; i++)
         check(wgot[i] == exp_w[i], (i == n_ew - 1 && !e[5]) ? "R6" : "R2",
               $sformatf("vec %0d write %0d data", v, i), wgot[i], exp_w[i]);
      check(done_cnt == 1, "R10", $sformatf("vec %0d done pulses", v), done_cnt, 1);
      check(dc_on == e[4] && ic_on == e[3], "R7",
            $sformatf("vec %0d L1 state restored {dc,ic}", v), {dc_on, ic_on}, {e[4], e[3]});
      check(!rd_req && !wr_req && step_req == '0 && !irq_mask, "R10",
            $sformatf("vec %0d quiet after done", v), {rd_req, wr_req, step_req}, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!done && !irq_mask && !rd_req && !wr_req && step_req == '0, "R1",
            "outputs during reset", {done, irq_mask, rd_req, wr_req, step_req}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(!done && !irq_mask && !rd_req && !wr_req && step_req == '0, "R1",
            "idle without start", {done, irq_mask, rd_req, wr_req, step_req}, 0);

      for (int v = 0; v < 8; v++) run_vector(v, 1'b0);

      // R10: start pulse during a run is ignored
      run_vector(0, 1'b1);
      run_vector(3, 1'b1);

      checks += r_checks;
      errors += r_errors;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks + r_checks + 1, errors + r_errors + 1);
      $finish;
   end

endmodule